// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Interface

This block is an SPI master controlled through a small byte-wide register bus. Software programs a mode byte (enable, clock phase, idle clock level, bit order, internal loopback) and a clock divisor, loads one transmit byte and issues a start command. The block then shifts exactly eight bits out on MOSI while it collects eight bits from MISO. When the frame is done, it places the collected byte in the receive register and raises a level interrupt.

There is no queueing. Each byte needs its own start command and ends with its own interrupt. The phase bit has the opposite sense to the common CPHA convention: a value of 1 samples on the leading SCK edge. The busy flag stays high for one clock after the ready flag rises. Chip selects are driven elsewhere.

Top module: `spi_byte_master`

## Requirements
- R1: After reset every register reads 0, SCK is low, MOSI is low and the interrupt is low.
- R2: A start command sets busy only when the enable bit (mode bit 3) is 1 and no transfer is in progress. A start command while disabled or busy has no effect on busy or on the timing of the current frame.
- R3: SCK makes 8 full periods of 4×(D+1) bus clocks each, where D is the divisor register (offset 5). The ready flag rises 32×(D+1) clocks after the clock edge that accepted the start. While idle, SCK rests at mode bit 1 (1 = high).
- R4: With mode bit 2 at 0 the byte moves MSB first on both MOSI and MISO. With mode bit 2 at 1 it moves LSB first.
- R5: With mode bit 4 at 1, MOSI is valid before the first leading SCK edge, data is sampled on leading edges and MOSI changes on trailing edges. With mode bit 4 at 0, MOSI changes on leading edges and data is sampled on trailing edges.
- R6: With mode bit 0 at 1, the received byte equals the transmitted byte whatever the MISO pin carries.
- R7: Status (offset 4) holds busy in bit 1 and ready in bit 0. At the end of a frame, ready, the interrupt and the receive data (offset 1) update on the same clock edge, and busy falls exactly one clock later.
- R8: Reading the receive data register (offset 1) clears ready and the interrupt on the next clock edge.
- R9: MOSI is driven low whenever no transfer is in progress.
- R10: Mode (offset 0), transmit data (offset 2) and divisor (offset 5) read back what was written. The start command is bit 0 of the control register (offset 3), which reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| re_i | input | 1 | Read strobe; needed for the clear-on-read of receive data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Receive-ready interrupt, level |
| sck_o | output | 1 | SPI clock |
| mosi_o | output | 1 | SPI data out |
| miso_i | input | 1 | SPI data in |

## Verification
The hardest condition to reach is a start command that arrives while a frame is already in flight. It must leave the frame's length and data untouched. The bench issues a second start part-way through a shift and checks that the ready edge still comes exactly 32×(D+1) clocks after the first start. A behavioural slave follows the SCK edges in all four phase/order combinations, so sampling on the wrong edge shows up as a corrupted byte in one direction or the other. Loopback runs with MISO driven to the opposite pattern, so a leak from the pin is visible.

// File: rtl/spi_byte_pkg.sv
package spi_byte_pkg;
  localparam int DATA_W = 8;
  localparam int DIV_W  = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_RXD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TXD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd3;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd5;

  localparam int M_LOOP   = 0;
  localparam int M_IDLEHI = 1;
  localparam int M_LSB    = 2;
  localparam int M_EN     = 3;
  localparam int M_LEAD   = 4;

  localparam int S_RDY  = 0;
  localparam int S_BUSY = 1;
  localparam int C_GO   = 0;
endpackage

// File: rtl/spi_byte_div.sv
module spi_byte_div #(
  parameter int DIV_W = spi_byte_pkg::DIV_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int CW = DIV_W + 1;

  logic [CW-1:0] cnt_q;

  // one tick per SCK half period: 2*(div+1) clocks
  assign tick_o = en_i && (cnt_q == {div_i, 1'b1});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || tick_o)    cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int W = spi_byte_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] tx_i,
  input  logic         lead_i,
  input  logic         lsb_i,
  input  logic         loop_i,
  input  logic         tick_i,
  input  logic         miso_i,
  output logic         busy_o,
  output logic         run_o,
  output logic         fin_o,
  output logic         tog_o,
  output logic         mosi_o,
  output logic [W-1:0] rx_o
);
  localparam int BW = $clog2(W);
  localparam int EW = BW + 1;
  localparam logic [EW-1:0] LAST = EW'(2 * W - 1);

  logic          busy_q, done_q, tog_q, mosi_q;
  logic [EW-1:0] edge_q;
  logic [W-1:0]  tx_q, rx_q, rx_nx;
  logic [BW-1:0] bit_n, nxt_n;
  logic          lead_edge, smp, din;

  function automatic logic [BW-1:0] pos(input logic [BW-1:0] n, input logic lsb);
    return lsb ? n : BW'(W - 1) - n;
  endfunction

  assign bit_n     = edge_q[EW-1:1];
  assign nxt_n     = bit_n + 1'b1;
  assign lead_edge = ~edge_q[0];
  assign smp       = tick_i && (lead_i ? lead_edge : ~lead_edge);
  assign din       = loop_i ? mosi_q : miso_i;
  assign fin_o     = tick_i && (edge_q == LAST);

  always_comb begin
    rx_nx = rx_q;
    if (smp) rx_nx[pos(bit_n, lsb_i)] = din;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      tog_q  <= 1'b0;
      mosi_q <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
        tog_q  <= 1'b0;
        edge_q <= '0;
        tx_q   <= tx_i;
        mosi_q <= lead_i ? tx_i[pos('0, lsb_i)] : 1'b0;
      end
    end else if (done_q) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (tick_i) begin
      tog_q  <= ~tog_q;
      edge_q <= edge_q + 1'b1;
      rx_q   <= rx_nx;
      if (lead_i && !lead_edge && edge_q != LAST) mosi_q <= tx_q[pos(nxt_n, lsb_i)];
      if (!lead_i && lead_edge)                   mosi_q <= tx_q[pos(bit_n, lsb_i)];
      if (edge_q == LAST)                         done_q <= 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign run_o  = busy_q && !done_q;
  assign tog_o  = tog_q;
  assign mosi_o = busy_q ? mosi_q : 1'b0;
  assign rx_o   = rx_nx;
endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master
  import spi_byte_pkg::*;
#(
  parameter int W  = DATA_W,
  parameter int DW = DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              we_i,
  input  logic              re_i,
  output logic [W-1:0]      rdata_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  logic [W-1:0]  mode_q, txd_q, rxd_q;
  logic [DW-1:0] div_q;
  logic          rbr_q;
  logic          busy, run, fin, tick, tog, go;
  logic [W-1:0]  rx_w;

  assign go = we_i && (addr_i == A_CTRL) && wdata_i[C_GO] && mode_q[M_EN] && !busy;

  spi_byte_div #(.DIV_W(DW)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  spi_byte_shift #(.W(W)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (go),
    .tx_i    (txd_q),
    .lead_i  (mode_q[M_LEAD]),
    .lsb_i   (mode_q[M_LSB]),
    .loop_i  (mode_q[M_LOOP]),
    .tick_i  (tick),
    .miso_i  (miso_i),
    .busy_o  (busy),
    .run_o   (run),
    .fin_o   (fin),
    .tog_o   (tog),
    .mosi_o  (mosi_o),
    .rx_o    (rx_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      txd_q  <= '0;
      div_q  <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_MODE:  mode_q <= wdata_i;
        A_TXD:   txd_q  <= wdata_i;
        A_DIV:   div_q  <= DW'(wdata_i);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_q <= '0;
      rbr_q <= 1'b0;
    end else if (fin) begin
      rxd_q <= rx_w;
      rbr_q <= 1'b1;
    end else if (re_i && addr_i == A_RXD) begin
      rbr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_MODE: rdata_o = mode_q;
      A_RXD:  rdata_o = rxd_q;
      A_TXD:  rdata_o = txd_q;
      A_STAT: begin
        rdata_o[S_BUSY] = busy;
        rdata_o[S_RDY]  = rbr_q;
      end
      A_DIV:  rdata_o = W'(div_q);
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = rbr_q;
  assign sck_o = mode_q[M_IDLEHI] ^ tog;
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk
  import spi_byte_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              rbr_i,
  input logic              fin_i,
  input logic [DATA_W-1:0] mode_i,
  input logic              sck_i,
  input logic              mosi_i,
  input logic              re_i,
  input logic [ADDR_W-1:0] addr_i
);
  AST_RDY_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rbr_i) |-> busy_i);                                      // R7
  AST_BUSY_DROPS_AFTER_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rbr_i) |=> !busy_i);                                     // R7
  AST_FIN_SETS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> rbr_i);                                              // R7
  AST_IDLE_SCK_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == mode_i[M_IDLEHI]);                        // R3
  AST_IDLE_MOSI_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !mosi_i);                                          // R9
  AST_DISABLED_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !mode_i[M_EN]) |=> !busy_i);                       // R2
  AST_READ_CLEARS_RDY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && addr_i == A_RXD && !fin_i) |=> !rbr_i);               // R8
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .busy_i (busy),
  .rbr_i  (rbr_q),
  .fin_i  (fin),
  .mode_i (mode_q),
  .sck_i  (sck_o),
  .mosi_i (mosi_o),
  .re_i   (re_i),
  .addr_i (addr_i)
);

// File: tb/spi_byte_master_test.sv
`timescale 1ns/1ps
module spi_byte_master_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] addr_i = 3'd4;
  logic [7:0] wdata_i = 8'h00;
  logic       we_i = 1'b0;
  logic       re_i = 1'b0;
  logic [7:0] rdata_o;
  logic       irq_o, sck_o, mosi_o;
  logic       miso_r = 1'b0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  spi_byte_master uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wdata_i(wdata_i),
    .we_i(we_i), .re_i(re_i), .rdata_o(rdata_o), .irq_o(irq_o),
    .sck_o(sck_o), .mosi_o(mosi_o), .miso_i(miso_r)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference of the control timing
  bit [7:0] m_mode = 0;
  int m_cdm = 0, m_cnt = 0, m_ticks = 0;
  bit m_busy = 0, m_done = 0, m_tog = 0, m_rbr = 0;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_mode = 0; m_cdm = 0; m_cnt = 0; m_ticks = 0;
      m_busy = 0; m_done = 0; m_tog = 0; m_rbr = 0;
    end else begin
      bit setr, start;
      setr = 0;
      cyc++;
      start = we_i && addr_i == 3 && wdata_i[0] && m_mode[3] && !m_busy;
      if (m_busy) begin
        if (m_done) begin
          m_busy = 0; m_done = 0;
        end else if (m_cnt == 2 * m_cdm + 1) begin
          m_cnt = 0; m_tog = ~m_tog; m_ticks++;
          if (m_ticks == 16) begin m_done = 1; setr = 1; end
        end else m_cnt++;
      end else if (start) begin
        m_busy = 1; m_cnt = 0; m_tog = 0; m_ticks = 0;
      end
      if (setr) m_rbr = 1;
      else if (re_i && addr_i == 1) m_rbr = 0;
      if (we_i && addr_i == 0) m_mode = wdata_i;
      if (we_i && addr_i == 5) m_cdm = wdata_i;
    end
  end

  // per-clock comparison
  always @(negedge clk_i) begin
    #1;
    if (rst_ni && !finished) begin
      chk("R3 sck", sck_o, m_mode[1] ^ m_tog);
      chk("R7 irq", irq_o, m_rbr);
      if (!m_busy) chk("R9 mosi idle", mosi_o, 0);
      if (addr_i == 4 && !we_i && !re_i)
        chk("R7 status", rdata_o, {6'b0, m_busy, m_rbr});
    end
  end

  // SPI slave following SCK edges
  bit sl_arm = 0, sl_ph = 0, sl_lsb = 0;
  bit [7:0] sl_tx = 0, sl_rx = 0;
  int sl_k = 0;

  function automatic int bpos(input int n, input bit lsb);
    return lsb ? n : 7 - n;
  endfunction

  always @(sck_o) begin
    if (sl_arm) begin
      bit leading;
      leading = (sl_k % 2) == 0;
      if (sl_ph == leading) sl_rx[bpos(sl_k / 2, sl_lsb)] = mosi_o;
      if (sl_ph && !leading && sl_k < 15) miso_r = sl_tx[bpos((sl_k + 1) / 2, sl_lsb)];
      if (!sl_ph && leading) miso_r = sl_tx[bpos(sl_k / 2, sl_lsb)];
      sl_k++;
    end
  end

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0; addr_i = 3'd4;
  endtask

  task automatic rd(input bit [2:0] a, output bit [7:0] d);
    @(negedge clk_i);
    addr_i = a; re_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0; addr_i = 3'd4;
  endtask

  task automatic xfer(input bit [7:0] mode, input bit [7:0] cdm, input bit [7:0] tx,
                      input bit [7:0] sdata, input bit [7:0] exp_rx, input bit extra_go,
                      input string tag);
    bit [7:0] d;
    int s, n;
    wr(3'd0, mode);
    wr(3'd5, cdm);
    wr(3'd2, tx);
    sl_ph = mode[4]; sl_lsb = mode[2]; sl_tx = sdata; sl_rx = 0; sl_k = 0;
    miso_r = mode[4] ? sdata[bpos(0, mode[2])] : 1'b0;
    sl_arm = 1;
    wr(3'd3, 8'h01);
    #1 s = cyc;
    n = 0;
    if (extra_go) begin
      repeat (3) @(negedge clk_i);
      wr(3'd3, 8'h01);  // must be ignored while busy
      #1;
    end
    while (!irq_o && n < 20000) begin @(negedge clk_i); #1; n++; end
    chk({tag, " R3 frame length"}, cyc - s, 32 * (cdm + 1));
    chk({tag, " R7 rdy with busy"}, rdata_o, 8'h03);
    @(negedge clk_i); #1;
    chk({tag, " R7 busy falls one clock later"}, rdata_o, 8'h01);
    sl_arm = 0;
    chk({tag, " R5/R4 slave saw tx"}, sl_rx, tx);
    chk({tag, " R16 slave edges"}, sl_k, 16);
    rd(3'd1, d);
    chk({tag, " R4/R5/R6 rx data"}, d, exp_rx);
    #1 chk({tag, " R8 irq cleared"}, irq_o, 0);
  endtask

  initial begin
    bit [7:0] d;
    repeat (3) @(negedge clk_i);
    #1;
    chk("R1 sck reset", sck_o, 0);
    chk("R1 mosi reset", mosi_o, 0);
    chk("R1 irq reset", irq_o, 0);
    rst_ni = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), d);
      chk("R1 reg reset", d, 0);
    end
    wr(3'd0, 8'h10); wr(3'd2, 8'hA5); wr(3'd5, 8'h03); wr(3'd3, 8'h00);
    rd(3'd0, d); chk("R10 mode readback", d, 8'h10);
    rd(3'd2, d); chk("R10 txd readback", d, 8'hA5);
    rd(3'd5, d); chk("R10 div readback", d, 8'h03);
    rd(3'd3, d); chk("R10 ctrl reads 0", d, 8'h00);
    // R2: start while disabled
    wr(3'd3, 8'h01);
    repeat (4) @(negedge clk_i);
    #1 chk("R2 disabled start ignored", rdata_o, 8'h00);
    // R4/R5 the four phase and order combinations
    xfer(8'h18, 8'd0, 8'hA5, 8'h3C, 8'h3C, 0, "lead msb");
    xfer(8'h08, 8'd1, 8'h96, 8'h5A, 8'h5A, 0, "trail msb");
    xfer(8'h1E, 8'd2, 8'h1D, 8'hC6, 8'hC6, 0, "lead lsb idlehi");
    xfer(8'h0E, 8'd0, 8'h6B, 8'hF0, 8'hF0, 0, "trail lsb idlehi");
    // R2: start while busy
    xfer(8'h18, 8'd3, 8'h3E, 8'h81, 8'h81, 1, "R2 busy start");
    // R6 loopback, MISO carries another pattern
    xfer(8'h19, 8'd1, 8'h7E, 8'h81, 8'h7E, 0, "R6 loop lead");
    xfer(8'h0D, 8'd0, 8'hC3, 8'h3C, 8'hC3, 0, "R6 loop trail");
    repeat (4) @(negedge clk_i);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule